// File: doc/BRIEF.md
# 48-bit Floating-Point Adder/Subtractor

This block adds or subtracts two 48-bit floating-point numbers held in a sign-magnitude format. Bit 47 is the sign. Bits 46:36 hold an unsigned 11-bit exponent with a bias of 1024. Bits 35:0 hold a 36-bit fraction whose binary point lies to the left of bit 35, with no hidden bit. The value of an operand is fraction × 2^(exponent − 1024), and the sign bit alone sets its sign.

The datapath has two register stages. The first stage swaps the operands so the one with the larger exponent leads, aligns the other one by a right shift, and forms the magnitude sum or difference. The second stage renormalises the result, adjusts the exponent, and detects overflow and underflow. A new operation may enter on every clock.

The result carries a zero flag, an overflow flag and an underflow flag. The format has no rounding modes and no special encodings. Bits shifted out during alignment are dropped.

Top module: `fadd48`

## Requirements
- R1: With op_sub=0 the result is the sign-magnitude sum of opa and opb. Field positions are sign in bit 47, exponent in bits 46:36 (unsigned, bias 1024) and fraction in bits 35:0, with the binary point left of bit 35.
- R2: With op_sub=1 the sign of opb is inverted before the same sign-magnitude addition, so the result is opa − opb.
- R3: The operand with the smaller exponent has its fraction shifted right by the exponent difference, and the bits shifted out are discarded. When the exponents are equal, opa leads. A difference of 36 or more leaves that operand contributing nothing.
- R4: If the fraction sum carries out of bit 35, the fraction is shifted right by one place (its lowest bit is dropped) and the exponent rises by one.
- R5: A nonzero result that is in range has bit 35 set. Each left shift used to reach that form lowers the exponent by one.
- R6: When the magnitudes cancel exactly, or both fractions are zero, all 48 result bits are 0, including the sign, and zero=1.
- R7: If the adjusted exponent would exceed 2047, overflow=1 and the result saturates to the result sign, exponent 2047 and an all-ones fraction. Overflow and underflow are never both set.
- R8: If the adjusted exponent would fall below 0, underflow=1 and the result is flushed to all zeros with zero=1.
- R9: An operand with an all-zero fraction contributes nothing, whatever its exponent. It never becomes the leading operand while the other fraction is nonzero.
- R10: out_valid rises exactly two clock edges after in_valid is sampled high, and the results shown belong to that operation. Back-to-back operations come out in order, one per cycle.
- R11: After reset, out_valid, result, zero, overflow and underflow are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and op_sub are valid this cycle |
| op_sub | input | 1 | 0 = add, 1 = subtract opb from opa |
| opa | input | 48 | First operand |
| opb | input | 48 | Second operand |
| out_valid | output | 1 | Result outputs are valid |
| result | output | 48 | Sum or difference |
| zero | output | 1 | Result is zero |
| overflow | output | 1 | Exponent exceeded 2047, result saturated |
| underflow | output | 1 | Exponent fell below 0, result flushed |

## Verification
The fragile cases are those where two functions act in the same cycle. In one, the carry-out renormalisation raises the exponent from 2047 to 2048, so overflow detection fires at once. In the other, cancellation needs a left shift that pushes an exponent of 0 below zero. Both are provoked by directed operands at the exponent extremes: equal large-exponent normalised fractions that carry, and near-equal small-exponent fractions whose difference needs a left shift. Random pairs with nearby exponents also reach these cases. Each output is judged against a bench model that reworks alignment, carry, normalisation and range checks from the requirements. A back-to-back burst confirms that results leave in order, one per cycle.

// File: rtl/fadd48_pkg.sv
`timescale 1ns/1ps
package fadd48_pkg;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = 36;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int LZ_W   = $clog2(FRAC_W + 1);
    localparam int EXPX_W = EXP_W + 2;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp_t;

    typedef struct packed {
        logic              valid;
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W:0]   mag;
    } sum_stage_t;

    typedef struct packed {
        logic valid;
        fp_t  res;
        logic zero;
        logic ovf;
        logic unf;
    } out_stage_t;

    typedef struct packed {
        sum_stage_t s1;
        out_stage_t o;
    } pipe_t;
endpackage

// File: rtl/fadd48_align.sv
`timescale 1ns/1ps
module fadd48_align
    import fadd48_pkg::*;
(
    input  fp_t               a_i,
    input  fp_t               b_i,
    output fp_t               big_o,
    output logic [FRAC_W-1:0] small_frac_o,
    output logic              small_sign_o
);
    logic             swap;
    fp_t              lo;
    logic [EXP_W-1:0] gap;

    always_comb begin
        // a zero fraction never leads while the other one is nonzero
        swap = (a_i.frac == '0) || ((b_i.frac != '0) && (b_i.exp > a_i.exp));
        big_o = swap ? b_i : a_i;
        lo    = swap ? a_i : b_i;
        gap   = big_o.exp - lo.exp;
        small_sign_o = lo.sign;
        if (lo.frac == '0 || gap >= EXP_W'(FRAC_W)) begin
            small_frac_o = '0;
        end else begin
            small_frac_o = lo.frac >> gap;
        end
    end
endmodule

// File: rtl/fadd48_magadd.sv
`timescale 1ns/1ps
module fadd48_magadd
    import fadd48_pkg::*;
(
    input  logic              big_sign_i,
    input  logic [FRAC_W-1:0] big_frac_i,
    input  logic              small_sign_i,
    input  logic [FRAC_W-1:0] small_frac_i,
    output logic              sign_o,
    output logic [FRAC_W:0]   mag_o
);
    always_comb begin
        if (big_sign_i == small_sign_i) begin
            mag_o  = {1'b0, big_frac_i} + {1'b0, small_frac_i};
            sign_o = big_sign_i;
        end else if (big_frac_i >= small_frac_i) begin
            mag_o  = {1'b0, big_frac_i - small_frac_i};
            sign_o = big_sign_i;
        end else begin
            mag_o  = {1'b0, small_frac_i - big_frac_i};
            sign_o = small_sign_i;
        end
    end
endmodule

// File: rtl/fadd48_norm.sv
`timescale 1ns/1ps
module fadd48_norm
    import fadd48_pkg::*;
(
    input  logic              sign_i,
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [FRAC_W:0]   mag_i,
    output fp_t               res_o,
    output logic              zero_o,
    output logic              ovf_o,
    output logic              unf_o
);
    logic              carry;
    logic [FRAC_W-1:0] body;
    logic [FRAC_W-1:0] shifted;
    logic [LZ_W-1:0]   lz;
    logic              found;
    logic [EXPX_W-1:0] ex;
    logic              ex_neg;
    logic              ex_big;

    always_comb begin
        carry = mag_i[FRAC_W];
        body  = carry ? mag_i[FRAC_W:1] : mag_i[FRAC_W-1:0];
        lz    = '0;
        found = 1'b0;
        for (int i = FRAC_W - 1; i >= 0; i--) begin
            if (!found && body[i]) begin
                lz    = LZ_W'(FRAC_W - 1 - i);
                found = 1'b1;
            end
        end
        shifted = body << lz;
        ex      = EXPX_W'(exp_i) + EXPX_W'(carry) - EXPX_W'(lz);
        ex_neg  = ex[EXPX_W-1];
        ex_big  = !ex_neg && (ex[EXPX_W-2:EXP_W] != '0);

        res_o  = '0;
        zero_o = 1'b0;
        ovf_o  = 1'b0;
        unf_o  = 1'b0;
        if (mag_i == '0) begin
            zero_o = 1'b1;
        end else if (ex_neg) begin
            zero_o = 1'b1;
            unf_o  = 1'b1;
        end else if (ex_big) begin
            ovf_o  = 1'b1;
            res_o  = '{sign: sign_i, exp: '1, frac: '1};
        end else begin
            res_o  = '{sign: sign_i, exp: ex[EXP_W-1:0], frac: shifted};
        end
    end
endmodule

// File: rtl/fadd48.sv
`timescale 1ns/1ps
module fadd48
    import fadd48_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              op_sub,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    output logic              out_valid,
    output logic [WORD_W-1:0] result,
    output logic              zero,
    output logic              overflow,
    output logic              underflow
);
    pipe_t             st_d, st_q;
    fp_t               a_in, b_eff, big;
    logic [FRAC_W-1:0] small_frac;
    logic              small_sign;
    logic              sum_sign;
    logic [FRAC_W:0]   sum_mag;
    fp_t               n_res;
    logic              n_zero, n_ovf, n_unf;

    always_comb begin
        a_in       = fp_t'(opa);
        b_eff      = fp_t'(opb);
        b_eff.sign = opb[WORD_W-1] ^ op_sub;
    end

    fadd48_align u_align (
        .a_i          (a_in),
        .b_i          (b_eff),
        .big_o        (big),
        .small_frac_o (small_frac),
        .small_sign_o (small_sign)
    );

    fadd48_magadd u_magadd (
        .big_sign_i   (big.sign),
        .big_frac_i   (big.frac),
        .small_sign_i (small_sign),
        .small_frac_i (small_frac),
        .sign_o       (sum_sign),
        .mag_o        (sum_mag)
    );

    fadd48_norm u_norm (
        .sign_i (st_q.s1.sign),
        .exp_i  (st_q.s1.exp),
        .mag_i  (st_q.s1.mag),
        .res_o  (n_res),
        .zero_o (n_zero),
        .ovf_o  (n_ovf),
        .unf_o  (n_unf)
    );

    always_comb begin
        st_d          = st_q;
        st_d.s1.valid = in_valid;
        if (in_valid) begin
            st_d.s1.sign = sum_sign;
            st_d.s1.exp  = big.exp;
            st_d.s1.mag  = sum_mag;
        end
        st_d.o.valid = st_q.s1.valid;
        if (st_q.s1.valid) begin
            st_d.o.res  = n_res;
            st_d.o.zero = n_zero;
            st_d.o.ovf  = n_ovf;
            st_d.o.unf  = n_unf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.o.valid;
    assign result    = st_q.o.res;
    assign zero      = st_q.o.zero;
    assign overflow  = st_q.o.ovf;
    assign underflow = st_q.o.unf;

    AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && zero |-> result == '0); // R6
    AST_NORM_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !zero |-> result[FRAC_W-1]); // R5
    AST_OVF_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && overflow |-> (result[WORD_W-2:0] == '1)); // R7
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(overflow && underflow)); // R7
    AST_UNF_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && underflow |-> zero && result == '0); // R8
    AST_STAGE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> st_q.s1.valid); // R10
    AST_STAGE_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.s1.valid |=> out_valid); // R10
endmodule

// File: tb/fadd48_test.sv
`timescale 1ns/1ps
module fadd48_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        op_sub = 1'b0;
    logic [47:0] opa = '0, opb = '0;
    logic        out_valid, zero, overflow, underflow;
    logic [47:0] result;
    int          n_checks = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    fadd48 uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
        .opa(opa), .opb(opb), .out_valid(out_valid), .result(result),
        .zero(zero), .overflow(overflow), .underflow(underflow)
    );

    function automatic logic [50:0] model(logic [47:0] a, logic [47:0] b, logic sub);
        logic sa, sb, sl, ss, s, swap;
        longint ea, eb, fa, fb, fl, fs, el, es, d, m, e;
        sa = a[47]; ea = longint'(a[46:36]); fa = longint'(a[35:0]);
        sb = b[47] ^ sub; eb = longint'(b[46:36]); fb = longint'(b[35:0]);
        swap = (fa == 0) || (fb != 0 && eb > ea);
        if (swap) begin sl = sb; el = eb; fl = fb; ss = sa; es = ea; fs = fa; end
        else      begin sl = sa; el = ea; fl = fa; ss = sb; es = eb; fs = fb; end
        d = el - es;
        if (fs == 0 || d >= 36) fs = 0; else fs = fs >> d;
        if (sl == ss) begin m = fl + fs; s = sl; end
        else if (fl >= fs) begin m = fl - fs; s = sl; end
        else begin m = fs - fl; s = ss; end
        if (m == 0) return {48'h0, 3'b100};
        e = el;
        if (m >= (64'sd1 <<< 36)) begin m = m >> 1; e = e + 1; end
        while (m < (64'sd1 <<< 35)) begin m = m <<< 1; e = e - 1; end
        if (e > 2047) return {s, 11'h7ff, 36'hf_ffff_ffff, 3'b010};
        if (e < 0) return {48'h0, 3'b101};
        return {s, e[10:0], m[35:0], 3'b000};
    endfunction

    task automatic check(string tag, logic [50:0] got, logic [50:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run_one(string tag, logic [47:0] a, logic [47:0] b, logic sub);
        @(negedge clk);
        opa = a; opb = b; op_sub = sub; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 early", {50'h0, out_valid}, 51'h0);
        @(negedge clk);
        check("R10 valid", {50'h0, out_valid}, 51'h1);
        check(tag, {result, zero, overflow, underflow}, model(a, b, sub));
    endtask

    function automatic logic [47:0] mk(logic s, int e, logic [35:0] f);
        return {s, e[10:0], f};
    endfunction

    initial begin
        #(5ns * 150000);
        n_fail++;
        $display("FAIL R10 watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [47:0] qa[8], qb[8];
        logic        qs[8];
        int          idx;
        repeat (3) @(negedge clk);
        check("R11 reset", {result, zero, overflow, underflow}, 51'h0);
        check("R11 reset valid", {50'h0, out_valid}, 51'h0);
        rst_n = 1'b1;

        run_one("R1 one plus one carry R4", mk(0, 1025, 36'h8_0000_0000), mk(0, 1025, 36'h8_0000_0000), 0);
        run_one("R1 mixed", mk(0, 1030, 36'hC_0000_0000), mk(0, 1028, 36'hA_0000_0001), 0);
        run_one("R2 three minus one", mk(0, 1026, 36'hC_0000_0000), mk(0, 1025, 36'h8_0000_0000), 1);
        run_one("R2 neg result", mk(0, 1025, 36'h8_0000_0000), mk(0, 1026, 36'hC_0000_0000), 1);
        run_one("R3 trunc shift", mk(0, 1040, 36'h8_0000_0000), mk(0, 1035, 36'hF_FFFF_FFFF), 0);
        run_one("R3 far gap", mk(1, 1100, 36'h9_0000_0000), mk(0, 1060, 36'hF_0000_0000), 0);
        run_one("R4 carry drop lsb", mk(0, 500, 36'hF_FFFF_FFFF), mk(0, 500, 36'h8_0000_0001), 0);
        run_one("R5 left shift", mk(0, 1024, 36'h8_0000_0000), mk(0, 1024, 36'h7_FFFF_F000), 1);
        run_one("R5 unnormalised in", mk(0, 900, 36'h0_0000_0F00), mk(0, 899, 36'h0_0000_0001), 0);
        run_one("R6 cancel", mk(1, 1200, 36'hA_5A5A_5A5A), mk(1, 1200, 36'hA_5A5A_5A5A), 1);
        run_one("R6 both zero", mk(1, 77, 36'h0), mk(0, 1500, 36'h0), 0);
        run_one("R7 overflow carry", mk(0, 2047, 36'h8_0000_0000), mk(0, 2047, 36'h8_0000_0000), 0);
        run_one("R7 overflow neg", mk(1, 2047, 36'hC_0000_0000), mk(0, 2047, 36'hC_0000_0000), 1);
        run_one("R8 underflow", mk(0, 0, 36'h8_0000_0000), mk(0, 0, 36'h4_0000_0000), 1);
        run_one("R8 edge no underflow", mk(0, 1, 36'h8_0000_0000), mk(0, 1, 36'h4_0000_0000), 1);
        run_one("R9 zero big exp", mk(0, 2000, 36'h0), mk(0, 1000, 36'h9_0000_0000), 0);
        run_one("R9 zero b sub", mk(0, 10, 36'hB_0000_0000), mk(1, 2047, 36'h0), 1);

        void'($urandom(32'd12345));
        for (int i = 0; i < 400; i++) begin
            logic [47:0] ra, rb;
            int ea, eb;
            ea = int'($urandom_range(2047, 0));
            eb = ($urandom_range(3, 0) == 0) ? int'($urandom_range(2047, 0))
                                             : ea + int'($urandom_range(40, 0)) - 20;
            if (eb < 0) eb = 0;
            if (eb > 2047) eb = 2047;
            ra = {1'($urandom), ea[10:0], 4'($urandom) | 4'h8, 32'($urandom)};
            rb = {1'($urandom), eb[10:0], 4'($urandom), 32'($urandom)};
            if (i % 7 == 0) rb[35:0] = ra[35:0];
            run_one("R1 R2 random", ra, rb, 1'($urandom));
        end

        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (k >= 2) begin
                idx = k - 2;
                check("R10 burst valid", {50'h0, out_valid}, 51'h1);
                check("R10 burst order", {result, zero, overflow, underflow},
                      model(qa[idx], qb[idx], qs[idx]));
            end
            if (k < 8) begin
                qa[k] = {1'($urandom), 11'd1000 + 11'($urandom_range(5, 0)), 4'h8 | 4'($urandom), 32'($urandom)};
                qb[k] = {1'($urandom), 11'd1000 + 11'($urandom_range(5, 0)), 4'($urandom), 32'($urandom)};
                qs[k] = 1'($urandom);
                opa = qa[k]; opb = qb[k]; op_sub = qs[k]; in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule